// File: doc/BRIEF.md
# Internal Clock Source Selector

This block chooses the system clock rate of a small microcontroller from two on-chip oscillators. One is a fast 8 MHz source and the other is a slow 31 kHz source. Both arrive as single-cycle tick enables on one reference clock. A power-of-two postscaler counts fast ticks and produces six slower rates. A 3-bit rate code then picks one of eight candidates: the slow source, one of the six postscaler outputs, or the fast source itself. The result is a single system-tick enable. No gated clock is produced anywhere.

The block also drives the two oscillator enables. Each enable depends on the rate code and on the enables of the power-up timer, the watchdog, the fail-safe clock monitor and two-speed start-up. An optional divider turns every fourth system tick into a clock-out tick for the oscillator output pin. In the general-purpose I/O pin mode, that divider output is suppressed and the pin is marked as released.

A change of the rate code waits for the next tick of the rate currently in force. Because of this, a switch never produces a shortened or merged tick.

Top module: `clk_src_sel`

## Requirements
- R1: After reset, the code in force is 000. With no tick on either input, `sys_tick` and `clkout_tick` are 0. With all enables low and `rate_sel` = 000, `slow_osc_en` is 1 and `fast_osc_en` is 0.
- R2: While code 000 is in force, `sys_tick` equals `slow_tick` in the same cycle, and fast ticks produce no system tick.
- R3: While code c (001..110) is in force, `sys_tick` pulses only together with the k-th fast tick counted since reset, where k is a multiple of 2^(7-c). Codes 001..110 give divisors 64, 32, 16, 8, 4 and 2. A slow tick then produces no system tick.
- R4: While code 111 is in force, `sys_tick` equals `fast_tick`.
- R5: A new value on `rate_sel` comes into force in the cycle after the next `sys_tick` of the code currently in force. Until then, the old code governs every tick.
- R6: `slow_osc_en` is 1 when any of the following holds:
  - the code in force is 000;
  - `rate_sel` is 000;
  - `pwrt_en`, `wdt_en` or `fscm_en` is 1;
  - `twospd_en` is 1 and `rate_sel` is 000.

  Otherwise `slow_osc_en` is 0.
- R7: `fast_osc_en` is 1 when any of the following holds:
  - the code in force is not 000;
  - `rate_sel` is not 000;
  - `twospd_en` is 1 and `rate_sel` is not 000.

  Otherwise `fast_osc_en` is 0.
- R8: With `io_mode` = 0, `clkout_tick` pulses together with every fourth `sys_tick` counted since reset (the 4th, 8th, and so on). The count includes slow-source ticks.
- R9: With `io_mode` = 1, `clkout_tick` stays 0 and `osc2_gpio` is 1. With `io_mode` = 0, `osc2_gpio` is 0.
- R10: The postscaler counts every fast tick regardless of the code in force. A rate selected later keeps the phase of the fast-tick count since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_tick | input | 1 | One-cycle enable per fast oscillator period |
| slow_tick | input | 1 | One-cycle enable per slow oscillator period |
| rate_sel | input | 3 | Requested rate code |
| pwrt_en | input | 1 | Power-up timer enabled |
| wdt_en | input | 1 | Watchdog enabled |
| fscm_en | input | 1 | Fail-safe clock monitor enabled |
| twospd_en | input | 1 | Two-speed start-up enabled |
| io_mode | input | 1 | 1 = oscillator pins released as I/O, 0 = clock-out on the second pin |
| sys_tick | output | 1 | System clock enable |
| clkout_tick | output | 1 | System tick divided by four |
| slow_osc_en | output | 1 | Slow oscillator enable |
| fast_osc_en | output | 1 | Fast oscillator enable |
| osc2_gpio | output | 1 | Second oscillator pin released as I/O |

## Verification
The switch-point and counter-hold assertions assume that `fast_tick` and `slow_tick` are single-cycle pulses, each followed by at least one idle reference cycle. They also assume the two ticks never arrive in the same cycle as each other. The stimulus honours this by emitting every tick through one task that raises exactly one tick line and then inserts an idle cycle. The stimulus changes `rate_sel` only in idle cycles, so each switch waits for a real tick of the old rate.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;

   // Default number of postscaler halving stages (divide by 2 .. 2**stages).
   localparam int DEF_POST_STAGES = 6;
   // Default clock-out divider is 2**DEF_CLKOUT_LOG2.
   localparam int DEF_CLKOUT_LOG2 = 2;

   // Pin-mode encoding on io_mode.
   typedef enum logic {
      PIN_CLKOUT = 1'b0,
      PIN_GPIO   = 1'b1
   } pin_mode_e;

   // Rate codes: slow source, each postscaler output, fast source direct.
   function automatic int num_codes(input int stages);
      return stages + 2;
   endfunction

   function automatic int code_width(input int stages);
      return $clog2(stages + 2);
   endfunction

endpackage

// File: rtl/clk_postscaler.sv
module clk_postscaler #(
   parameter int STAGES = clk_sel_pkg::DEF_POST_STAGES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fast_tick,
   output logic [STAGES:0]   div_tick
);

   if (STAGES < 1) begin : g_bad_stages
      $error("clk_postscaler: STAGES must be at least 1");
   end

   logic [STAGES-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (fast_tick)
         cnt_q <= cnt_q + 1'b1;
   end

   // Index 0 is the undivided fast tick; index k divides by 2**k.
   assign div_tick[0] = fast_tick;

   for (genvar k = 1; k <= STAGES; k++) begin : g_stage
      assign div_tick[k] = fast_tick & (&cnt_q[k-1:0]);
   end

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fast_tick |=> $stable(cnt_q))
      else $error("postscaler counter moved without a fast tick"); // R10

   AST_DIV_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      (|div_tick) |-> fast_tick)
      else $error("divided tick without a fast tick"); // R3

endmodule

// File: rtl/clk_rate_mux.sv
module clk_rate_mux #(
   parameter int STAGES = clk_sel_pkg::DEF_POST_STAGES,
   parameter int SEL_W  = clk_sel_pkg::code_width(STAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic [STAGES:0]   div_tick,
   input  logic [SEL_W-1:0]  req_sel,
   output logic [SEL_W-1:0]  act_sel,
   output logic              sys_tick
);

   localparam int NCODES = clk_sel_pkg::num_codes(STAGES);

   if (NCODES > (1 << SEL_W)) begin : g_bad_width
      $error("clk_rate_mux: SEL_W too narrow for the rate codes");
   end

   logic [NCODES-1:0] cand;

   // Code 0 is the slow source; code c picks fast/2**(NCODES-1-c).
   assign cand[0] = slow_tick;
   for (genvar c = 1; c < NCODES; c++) begin : g_cand
      assign cand[c] = div_tick[NCODES-1-c];
   end

   assign sys_tick = cand[act_sel];

   // The request is taken only on a tick of the rate in force.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         act_sel <= '0;
      else if (sys_tick)
         act_sel <= req_sel;
   end

   AST_SWITCH_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      (act_sel != $past(act_sel)) |-> $past(sys_tick))
      else $error("rate code changed away from a tick boundary"); // R5

   AST_SWITCH_TAKES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      sys_tick |=> (act_sel == $past(req_sel)))
      else $error("requested rate not taken at the boundary"); // R5

endmodule

// File: rtl/clk_osc_enable.sv
module clk_osc_enable #(
   parameter int SEL_W = clk_sel_pkg::code_width(clk_sel_pkg::DEF_POST_STAGES)
) (
   input  logic [SEL_W-1:0] act_sel,
   input  logic [SEL_W-1:0] req_sel,
   input  logic             pwrt_en,
   input  logic             wdt_en,
   input  logic             fscm_en,
   input  logic             twospd_en,
   output logic             slow_osc_en,
   output logic             fast_osc_en
);

   logic act_slow, req_slow, periph_need, start_slow, start_fast;

   assign act_slow    = (act_sel == '0);
   assign req_slow    = (req_sel == '0);
   assign periph_need = pwrt_en | wdt_en | fscm_en;
   assign start_slow  = twospd_en & req_slow;
   assign start_fast  = twospd_en & ~req_slow;

   assign slow_osc_en = act_slow | req_slow | periph_need | start_slow;
   assign fast_osc_en = ~act_slow | ~req_slow | start_fast;

endmodule

// File: rtl/clk_out_div.sv
module clk_out_div #(
   parameter int LOG2 = clk_sel_pkg::DEF_CLKOUT_LOG2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sys_tick,
   input  logic io_mode,
   output logic clkout_tick
);

   if (LOG2 < 1) begin : g_bad_log2
      $error("clk_out_div: LOG2 must be at least 1");
   end

   logic [LOG2-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (sys_tick)
         cnt_q <= cnt_q + 1'b1;
   end

   assign clkout_tick = sys_tick & (&cnt_q) &
                        (io_mode == clk_sel_pkg::PIN_CLKOUT);

   AST_CLKOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_tick |=> $stable(cnt_q))
      else $error("clock-out divider moved without a system tick"); // R8

endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel #(
   parameter int POST_STAGES = clk_sel_pkg::DEF_POST_STAGES,
   parameter int SEL_W       = clk_sel_pkg::code_width(POST_STAGES),
   parameter int CLKOUT_LOG2 = clk_sel_pkg::DEF_CLKOUT_LOG2,
   parameter bit CLKOUT_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fast_tick,
   input  logic             slow_tick,
   input  logic [SEL_W-1:0] rate_sel,
   input  logic             pwrt_en,
   input  logic             wdt_en,
   input  logic             fscm_en,
   input  logic             twospd_en,
   input  logic             io_mode,
   output logic             sys_tick,
   output logic             clkout_tick,
   output logic             slow_osc_en,
   output logic             fast_osc_en,
   output logic             osc2_gpio
);

   if (SEL_W != clk_sel_pkg::code_width(POST_STAGES)) begin : g_bad_sel_w
      $error("clk_src_sel: SEL_W does not match POST_STAGES");
   end

   logic [POST_STAGES:0] div_tick;
   logic [SEL_W-1:0]     act_sel;

   clk_postscaler #(.STAGES(POST_STAGES)) u_post (
      .clk       (clk),
      .rst_n     (rst_n),
      .fast_tick (fast_tick),
      .div_tick  (div_tick)
   );

   clk_rate_mux #(.STAGES(POST_STAGES), .SEL_W(SEL_W)) u_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .slow_tick (slow_tick),
      .div_tick  (div_tick),
      .req_sel   (rate_sel),
      .act_sel   (act_sel),
      .sys_tick  (sys_tick)
   );

   clk_osc_enable #(.SEL_W(SEL_W)) u_osc (
      .act_sel     (act_sel),
      .req_sel     (rate_sel),
      .pwrt_en     (pwrt_en),
      .wdt_en      (wdt_en),
      .fscm_en     (fscm_en),
      .twospd_en   (twospd_en),
      .slow_osc_en (slow_osc_en),
      .fast_osc_en (fast_osc_en)
   );

   if (CLKOUT_EN) begin : g_clkout
      clk_out_div #(.LOG2(CLKOUT_LOG2)) u_div (
         .clk         (clk),
         .rst_n       (rst_n),
         .sys_tick    (sys_tick),
         .io_mode     (io_mode),
         .clkout_tick (clkout_tick)
      );
   end else begin : g_no_clkout
      assign clkout_tick = 1'b0;
   end

   assign osc2_gpio = (io_mode == clk_sel_pkg::PIN_GPIO);

   AST_SLOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (act_sel == '0) |-> (sys_tick == slow_tick))
      else $error("slow code in force but system tick differs"); // R2

   AST_SLOW_EN_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
      (pwrt_en | wdt_en | fscm_en) |-> slow_osc_en)
      else $error("slow oscillator off while a dependant is enabled"); // R6

   AST_FAST_EN_TWOSPD: assert property (@(posedge clk) disable iff (!rst_n)
      (twospd_en && rate_sel != '0) |-> fast_osc_en)
      else $error("fast oscillator off during two-speed start"); // R7

   AST_CLKOUT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      clkout_tick |-> sys_tick)
      else $error("clock-out tick without a system tick"); // R8

   AST_GPIO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      osc2_gpio |-> !clkout_tick)
      else $error("clock-out active while pin released"); // R9

endmodule

// File: tb/clk_src_sel_bench.sv
module clk_src_sel_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fast_tick = 1'b0, slow_tick = 1'b0;
   logic [2:0] rate_sel = 3'd0;
   logic       pwrt_en = 1'b0, wdt_en = 1'b0, fscm_en = 1'b0, twospd_en = 1'b0;
   logic       io_mode = 1'b0;
   logic       sys_tick, clkout_tick, slow_osc_en, fast_osc_en, osc2_gpio;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   clk_src_sel u_clk_src_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .fast_tick   (fast_tick),
      .slow_tick   (slow_tick),
      .rate_sel    (rate_sel),
      .pwrt_en     (pwrt_en),
      .wdt_en      (wdt_en),
      .fscm_en     (fscm_en),
      .twospd_en   (twospd_en),
      .io_mode     (io_mode),
      .sys_tick    (sys_tick),
      .clkout_tick (clkout_tick),
      .slow_osc_en (slow_osc_en),
      .fast_osc_en (fast_osc_en),
      .osc2_gpio   (osc2_gpio)
   );

   // Rows: {phase_b, rate_sel[2:0], pwrt, wdt, fscm, twospd, exp_slow, exp_fast}
   // phase A: code 000 in force; phase B: code 110 in force.
   localparam int NROWS = 12;
   localparam logic [9:0] ENA_TBL [NROWS] = '{
      10'b0_000_0000_10, 10'b0_011_0000_11, 10'b0_000_0001_10, 10'b0_101_0001_11,
      10'b1_110_0000_01, 10'b1_110_1000_11, 10'b1_010_0100_11, 10'b1_111_0010_11,
      10'b1_011_0001_01, 10'b1_000_0000_11, 10'b1_000_0001_11, 10'b1_001_0000_01
   };

   task automatic check(input logic got, input logic exp, input string req, input string what);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s: got=%0b expected=%0b", req, what, got, exp);
      end
   endtask

   task automatic check_int(input int got, input int exp, input string req, input string what);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s %s: got=%0d expected=%0d", req, what, got, exp);
      end
   endtask

   // Drive one cycle of ticks; outputs are read 1 ns after the falling edge.
   task automatic cyc(input logic f, input logic s);
      @(negedge clk);
      fast_tick = f;
      slow_tick = s;
      #1;
   endtask

   task automatic idle();
      cyc(1'b0, 1'b0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      fast_tick = 1'b0; slow_tick = 1'b0; rate_sel = 3'd0;
      pwrt_en = 1'b0; wdt_en = 1'b0; fscm_en = 1'b0; twospd_en = 1'b0;
      io_mode = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: got=expired expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic cur_phase;
      int bad, cnt, first;

      // R1: reset state
      do_reset();
      idle();
      check(sys_tick, 1'b0, "R1", "sys_tick idle after reset");
      check(clkout_tick, 1'b0, "R1", "clkout idle after reset");
      check(slow_osc_en, 1'b1, "R1", "slow_osc_en after reset");
      check(fast_osc_en, 1'b0, "R1", "fast_osc_en after reset");

      // R6/R7: enable table walk
      cur_phase = 1'b0;
      for (int i = 0; i < NROWS; i++) begin
         if (ENA_TBL[i][9] != cur_phase) begin
            do_reset();
            rate_sel = 3'd6;
            cyc(1'b0, 1'b1);   // slow tick puts code 110 in force
            idle();
            cur_phase = 1'b1;
         end
         @(negedge clk);
         rate_sel  = ENA_TBL[i][8:6];
         pwrt_en   = ENA_TBL[i][5];
         wdt_en    = ENA_TBL[i][4];
         fscm_en   = ENA_TBL[i][3];
         twospd_en = ENA_TBL[i][2];
         #1;
         check(slow_osc_en, ENA_TBL[i][1], "R6", $sformatf("slow enable row %0d", i));
         check(fast_osc_en, ENA_TBL[i][0], "R7", $sformatf("fast enable row %0d", i));
      end

      // R2: code 000 follows the slow tick, ignores fast ticks
      do_reset();
      bad = 0;
      for (int k = 0; k < 20; k++) begin
         cyc(1'b1, 1'b0); if (sys_tick !== 1'b0) bad++;
         idle();
      end
      cyc(1'b0, 1'b1); if (sys_tick !== 1'b1) bad++;
      idle();
      check_int(bad, 0, "R2", "slow code mismatches");

      // R3, R4: every code from 001 to 111
      for (int c = 1; c <= 7; c++) begin
         int d;
         d = 1 << (7 - c);
         do_reset();
         rate_sel = c[2:0];
         cyc(1'b0, 1'b1);
         idle();
         bad = 0;
         for (int k = 1; k <= 128; k++) begin
            cyc(1'b1, 1'b0);
            if (sys_tick !== ((k % d) == 0)) bad++;
            idle();
         end
         cyc(1'b0, 1'b1);
         if (sys_tick !== 1'b0) bad++;
         idle();
         if (c == 7) check_int(bad, 0, "R4", "direct fast code mismatches");
         else        check_int(bad, 0, "R3", $sformatf("code %0d mismatches", c));
      end

      // R5: switch from /64 to direct only at the /64 boundary
      do_reset();
      rate_sel = 3'd1;
      cyc(1'b0, 1'b1);
      idle();
      for (int k = 1; k <= 10; k++) begin cyc(1'b1, 1'b0); idle(); end
      rate_sel = 3'd7;
      cnt = 0;
      for (int k = 11; k <= 63; k++) begin
         cyc(1'b1, 1'b0); if (sys_tick) cnt++;
         idle();
      end
      check_int(cnt, 0, "R5", "ticks before old boundary");
      cyc(1'b1, 1'b0);
      check(sys_tick, 1'b1, "R5", "tick at old boundary 64");
      idle();
      cyc(1'b1, 1'b0);
      check(sys_tick, 1'b1, "R5", "new rate tick 65");
      idle();

      // R10: postscaler phase kept while slow code in force
      do_reset();
      for (int k = 1; k <= 10; k++) begin cyc(1'b1, 1'b0); idle(); end
      rate_sel = 3'd4;
      cyc(1'b0, 1'b1);
      idle();
      first = 0;
      for (int k = 11; k <= 24; k++) begin
         cyc(1'b1, 1'b0);
         if (sys_tick && first == 0) first = k;
         idle();
      end
      check_int(first, 16, "R10", "first /8 tick index");

      // R8: clock-out every fourth system tick
      do_reset();
      rate_sel = 3'd7;
      cyc(1'b0, 1'b1);          // system tick #1
      check(clkout_tick, 1'b0, "R8", "clkout on tick 1");
      idle();
      bad = 0;
      for (int k = 1; k <= 15; k++) begin
         cyc(1'b1, 1'b0);       // system tick #k+1
         if (clkout_tick !== (((k + 1) % 4) == 0)) bad++;
         idle();
      end
      check_int(bad, 0, "R8", "clkout pattern mismatches");
      check(osc2_gpio, 1'b0, "R9", "pin held in clock-out mode");

      // R9: I/O pin mode silences clock-out
      @(negedge clk);
      io_mode = 1'b1;
      #1;
      check(osc2_gpio, 1'b1, "R9", "pin released in I/O mode");
      cnt = 0;
      for (int k = 0; k < 12; k++) begin
         cyc(1'b1, 1'b0); if (clkout_tick) cnt++;
         idle();
      end
      check_int(cnt, 0, "R9", "clkout pulses in I/O mode");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule